// File: doc/BRIEF.md
# Serial Control Word Decoder with Reference-Code Register

This block takes a 12-bit control word that arrives one bit per clock, most significant bit first, while an access window input is held high. Once the twelfth bit has been captured, the word is split into a channel selector, a conversion-pair selector, five feature flags and a three-bit command code. These settings drive the rest of the converter front end.

Three one-shot commands use a two-access protocol. A write command arms the block, and the next complete access loads a 10-bit reference-DAC code instead of control fields. A readback command arms the block, and during the next access the serial input is ignored while the output shifter is asked to send the stored code. A reset command returns every setting to its power-up value, pulses a reset output and blocks the serial input for a short guard interval.

An access that ends before twelve bits have arrived is dropped. It changes nothing, and it does not cancel an armed command.

Top module: `cfg_word_decoder`

## Requirements
- R1: While `frm_i` is high, each rising clock edge captures `sdi_i` as the next bit, most significant first. Settings change at the edge that captures the twelfth bit. Any further bits in the same window are ignored until `frm_i` has been low for at least one edge.
- R2: After `rst_ni` the channel, pair and feature outputs are all zero, `dac_code_o` is 0x3FF, `rst_pulse_o` and `rb_req_o` are low, and no command is armed.
- R3: Every control word loads `chan_sel_o` from bits 11:10 and `pair_sel_o` from bits 9:8.
- R4: The feature outputs (bit 7 deep power-down, bit 6 nap, bit 5 auto-nap, bit 4 reference off, bit 3 special read) load only from a control word whose bits 9:8 are 01. Otherwise they keep their values.
- R5: Bits 2:0 act only when bits 9:8 are 01. Code 001 arms a write, 011 arms a readback and 101 resets. Every other code, and every code under another pair value, does nothing.
- R6: The complete access after an armed write loads bits 9:0 into `dac_code_o`. Bits 11:10 and all other outputs are left unchanged, and the arm is cleared.
- R7: During an access after an armed readback, `rb_req_o` is high and `rb_word_o` shows 0000, then the 10-bit code, then 00. The input bits are ignored, so no output changes when that access completes, and the arm is cleared.
- R8: A reset command restores the R2 values at its twelfth edge. From the next cycle `rst_pulse_o` is high for RST_GAP cycles, and no bit is captured while it is high.
- R9: An access that ends after fewer than twelve bits changes no output and keeps any armed command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_i | input | 1 | Access window; high while a word is being shifted |
| sdi_i | input | 1 | Serial data in |
| chan_sel_o | output | 2 | Channel selector |
| pair_sel_o | output | 2 | Conversion-pair selector |
| deep_pd_o | output | 1 | Deep power-down flag |
| nap_pd_o | output | 1 | Nap power-down flag |
| auto_nap_o | output | 1 | Auto-nap flag |
| ref_off_o | output | 1 | Internal reference off |
| spec_rd_o | output | 1 | Special read mode |
| dac_code_o | output | 10 | Reference DAC code |
| rst_pulse_o | output | 1 | Reset pulse, RST_GAP cycles long |
| rb_req_o | output | 1 | Request to send DAC readback data |
| rb_word_o | output | 16 | Readback frame for the output shifter |

## Verification
Assertions check on every cycle that the bit counter never passes twelve and completes at most once per window. They also check that no word completes during the reset guard interval, that the feature flags and the DAC code move only on their own load strobes or a reset, and that a reset leaves the defaults behind.

Only the bench scenarios can show that the two-access protocol works end to end. These scenarios cover a data word whose top bits do not reach the channel selector, an ignored readback input, a cut-short access that keeps its arm, and a word sent into the guard interval that is lost.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int WORD_W = 12;
  localparam int DAC_W  = 10;
  localparam int FEAT_W = 5;
  localparam int RB_W   = DAC_W + 6;
  localparam logic [DAC_W-1:0] DAC_DEFAULT = '1;
  localparam logic [1:0]       PAIR_FEAT   = 2'b01;

  // Field order matches the serial word, bit 11 first.
  typedef struct packed {
    logic [1:0]        chan;
    logic [1:0]        pair;
    logic [FEAT_W-1:0] feat;   // [4] deep pd, [3] nap, [2] auto-nap, [1] ref off, [0] special read
    logic [2:0]        cmd;
  } ctl_t;

  typedef enum logic [1:0] {ARM_NONE = 2'd0, ARM_WR = 2'd1, ARM_RD = 2'd2} arm_e;
  typedef enum logic [1:0] {K_NOP = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_RST = 2'd3} cmd_e;

  function automatic logic f_is_feat(input ctl_t c);
    return c.pair == PAIR_FEAT;
  endfunction

  function automatic cmd_e f_kind(input ctl_t c);
    if (!f_is_feat(c)) return K_NOP;
    case (c.cmd)
      3'b001:  return K_WR;
      3'b011:  return K_RD;
      3'b101:  return K_RST;
      default: return K_NOP;
    endcase
  endfunction

  function automatic logic [RB_W-1:0] f_rb_word(input logic [DAC_W-1:0] d);
    return {4'b0000, d, 2'b00};
  endfunction

endpackage

// File: rtl/cfgdec_shift.sv
module cfgdec_shift
  import cfgdec_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frm_i,
  input  logic         sdi_i,
  input  logic         hold_i,
  output logic         done_o,
  output logic [W-1:0] word_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic          take;

  assign take   = frm_i && !hold_i && (cnt_q < FULL);
  assign done_o = take && (cnt_q == LAST);
  assign word_o = {sh_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!frm_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[W-3:0], sdi_i};
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

  a_r1_one_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/cfgdec_cmd.sv
module cfgdec_cmd
  import cfgdec_pkg::*;
#(
  parameter int RST_GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ld_ctl_o,
  output logic              ld_feat_o,
  output logic              ld_dac_o,
  output logic              do_rst_o,
  output logic              hold_o,
  output logic              rst_pulse_o,
  output logic              rb_req_o
);

  localparam int GW = $clog2(RST_GAP + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(RST_GAP);

  arm_e          arm_q, arm_d;
  logic [GW-1:0] gap_q;
  ctl_t          ctl;
  cmd_e          kind;

  assign ctl  = ctl_t'(word_i);
  assign kind = f_kind(ctl);

  assign ld_ctl_o  = done_i && (arm_q == ARM_NONE);
  assign ld_feat_o = ld_ctl_o && f_is_feat(ctl);
  assign ld_dac_o  = done_i && (arm_q == ARM_WR);
  assign do_rst_o  = ld_ctl_o && (kind == K_RST);

  always_comb begin
    arm_d = arm_q;
    if (done_i) begin
      if (arm_q != ARM_NONE)   arm_d = ARM_NONE;
      else if (kind == K_WR)   arm_d = ARM_WR;
      else if (kind == K_RD)   arm_d = ARM_RD;
      else                     arm_d = ARM_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= ARM_NONE;
      gap_q <= '0;
    end else begin
      arm_q <= arm_d;
      if (do_rst_o)          gap_q <= GAP_LOAD;
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  assign hold_o      = (gap_q != '0);
  assign rst_pulse_o = hold_o;
  assign rb_req_o    = (arm_q == ARM_RD) && frm_i;

  a_r8_gap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> !done_i);

  a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |-> $past(do_rst_o));

  a_r6_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && arm_q != ARM_NONE) |=> arm_q == ARM_NONE);

  a_r7_rb_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o |-> !ld_ctl_o && !ld_dac_o);

endmodule

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
  import cfgdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ctl_i,
  input  logic              ld_feat_i,
  input  logic              ld_dac_i,
  input  logic              do_rst_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        chan_o,
  output logic [1:0]        pair_o,
  output logic [FEAT_W-1:0] feat_o,
  output logic [DAC_W-1:0]  dac_o
);

  ctl_t ctl;
  assign ctl = ctl_t'(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o <= '0;
      pair_o <= '0;
      feat_o <= '0;
      dac_o  <= DAC_DEFAULT;
    end else if (do_rst_i) begin
      chan_o <= '0;
      pair_o <= '0;
      feat_o <= '0;
      dac_o  <= DAC_DEFAULT;
    end else begin
      if (ld_ctl_i) begin
        chan_o <= ctl.chan;
        pair_o <= ctl.pair;
      end
      if (ld_feat_i) feat_o <= ctl.feat;
      if (ld_dac_i)  dac_o  <= word_i[DAC_W-1:0];
    end
  end

  a_r4_feat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_feat_i && !do_rst_i) |=> $stable(feat_o));

  a_r6_dac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_dac_i && !do_rst_i) |=> $stable(dac_o));

  a_r8_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rst_i |=> (dac_o == DAC_DEFAULT) && (feat_o == '0) && (chan_o == '0) && (pair_o == '0));

endmodule

// File: rtl/cfg_word_decoder.sv
module cfg_word_decoder
  import cfgdec_pkg::*;
#(
  parameter int RST_GAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_i,
  input  logic             sdi_i,
  output logic [1:0]       chan_sel_o,
  output logic [1:0]       pair_sel_o,
  output logic             deep_pd_o,
  output logic             nap_pd_o,
  output logic             auto_nap_o,
  output logic             ref_off_o,
  output logic             spec_rd_o,
  output logic [9:0]       dac_code_o,
  output logic             rst_pulse_o,
  output logic             rb_req_o,
  output logic [15:0]      rb_word_o
);

  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              hold;
  logic              ld_ctl, ld_feat, ld_dac, do_rst;
  logic [FEAT_W-1:0] feat;

  cfgdec_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frm_i  (frm_i),
    .sdi_i  (sdi_i),
    .hold_i (hold),
    .done_o (word_done),
    .word_o (word)
  );

  cfgdec_cmd #(.RST_GAP(RST_GAP)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_i       (frm_i),
    .done_i      (word_done),
    .word_i      (word),
    .ld_ctl_o    (ld_ctl),
    .ld_feat_o   (ld_feat),
    .ld_dac_o    (ld_dac),
    .do_rst_o    (do_rst),
    .hold_o      (hold),
    .rst_pulse_o (rst_pulse_o),
    .rb_req_o    (rb_req_o)
  );

  cfgdec_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_ctl_i  (ld_ctl),
    .ld_feat_i (ld_feat),
    .ld_dac_i  (ld_dac),
    .do_rst_i  (do_rst),
    .word_i    (word),
    .chan_o    (chan_sel_o),
    .pair_o    (pair_sel_o),
    .feat_o    (feat),
    .dac_o     (dac_code_o)
  );

  assign deep_pd_o  = feat[4];
  assign nap_pd_o   = feat[3];
  assign auto_nap_o = feat[2];
  assign ref_off_o  = feat[1];
  assign spec_rd_o  = feat[0];
  assign rb_word_o  = f_rb_word(dac_code_o);

  a_r7_rb_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_req_o |=> $stable(dac_code_o));

endmodule

// File: tb/sim_cfg_word_decoder.sv
`timescale 1ns/1ps
module sim_cfg_word_decoder;

  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm = 1'b0;
  logic sdi = 1'b0;

  logic [1:0]  chan, pair;
  logic        dp, nap, anap, rpd, s4, rst_p, rbq;
  logic [9:0]  dac;
  logic [15:0] rbw;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_word_decoder #(.RST_GAP(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frm_i(frm), .sdi_i(sdi),
    .chan_sel_o(chan), .pair_sel_o(pair),
    .deep_pd_o(dp), .nap_pd_o(nap), .auto_nap_o(anap), .ref_off_o(rpd), .spec_rd_o(s4),
    .dac_code_o(dac), .rst_pulse_o(rst_p), .rb_req_o(rbq), .rb_word_o(rbw)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_bits, m_word, m_arm, m_gap, m_chan, m_pair, m_feat, m_dac;

  task automatic m_reset();
    m_bits = 0; m_word = 0; m_arm = 0; m_gap = 0;
    m_chan = 0; m_pair = 0; m_feat = 0; m_dac = 'h3FF;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit got_all;
      got_all = 0;
      if (frm && m_gap == 0 && m_bits < 12) begin
        m_word = ((m_word << 1) | int'(sdi)) & 'hFFF;
        m_bits++;
        got_all = (m_bits == 12);
      end
      if (!frm) m_bits = 0;
      if (m_gap > 0) m_gap--;
      if (got_all) begin
        if (m_arm == 1) begin m_dac = m_word % 1024; m_arm = 0; end
        else if (m_arm == 2) m_arm = 0;
        else begin
          m_chan = m_word / 1024;
          m_pair = (m_word / 256) % 4;
          if (m_pair == 1) begin
            m_feat = (m_word / 8) % 32;
            case (m_word % 8)
              1: m_arm = 1;
              3: m_arm = 2;
              5: begin m_reset(); m_gap = GAP; end
              default: ;
            endcase
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check("R3", "chan", int'(chan), m_chan);
      check("R3", "pair", int'(pair), m_pair);
      check("R4", "feat", int'({dp, nap, anap, rpd, s4}), m_feat);
      check("R6", "dac", int'(dac), m_dac);
      check("R8", "rst_pulse", int'(rst_p), int'(m_gap != 0));
      check("R7", "rb_req", int'(rbq), int'(m_arm == 2 && frm));
      check("R7", "rb_word", int'(rbw), m_dac * 4);
    end
  end

  task automatic put_bit(input logic b);
    frm = 1'b1; sdi = b;
    @(posedge clk); #1;
  endtask

  task automatic xfer(input logic [11:0] w, input int n);
    for (int i = 0; i < n; i++) put_bit(w[11-i]);
    frm = 1'b0; sdi = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R2 reset state
    check("R2", "chan", int'(chan), 0);
    check("R2", "feat", int'({dp, nap, anap, rpd, s4}), 0);
    check("R2", "dac", int'(dac), 'h3FF);
    check("R2", "rst/rb", int'({rst_p, rbq}), 0);

    // R3 and R4: pair 11 loads channel/pair, not features
    xfer(12'b11_11_11111_000, 12);
    check("R3", "chan", int'(chan), 3);
    check("R4", "feat held", int'({dp, nap, anap, rpd, s4}), 0);

    // R1: nothing before the 12th bit, extra bits ignored
    for (int i = 0; i < 11; i++) put_bit(i == 0);
    check("R1", "pair before 12th", int'(pair), 3);
    put_bit(1'b0);
    check("R1", "chan at 12th", int'(chan), 2);
    check("R1", "pair at 12th", int'(pair), 0);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    check("R1", "extra bits", int'(chan), 2);
    frm = 1'b0; @(posedge clk); #1;

    // R4 features under pair 01
    xfer(12'b01_01_10101_000, 12);
    check("R4", "feat", int'({dp, nap, anap, rpd, s4}), 'b10101);

    // R5: write code under pair 00 does nothing
    xfer(12'b00_00_00000_001, 12);
    xfer(12'b11_11_00000_000, 12);
    check("R5", "chan not data", int'(chan), 3);
    check("R5", "dac kept", int'(dac), 'h3FF);
    // R5: unused code under pair 01 arms nothing
    xfer(12'b01_01_10101_111, 12);
    xfer(12'b10_11_00000_000, 12);
    check("R5", "code 111", int'(chan), 2);

    // R6: armed write loads DAC, top bits not channel
    xfer(12'b10_01_10101_001, 12);
    xfer(12'h155, 12);
    check("R6", "dac", int'(dac), 'h155);
    check("R6", "chan kept", int'(chan), 2);
    xfer(12'b10_01_10101_001, 12);
    xfer(12'hEAA, 12);
    check("R6", "dac 2", int'(dac), 'h2AA);
    check("R6", "chan kept 2", int'(chan), 2);

    // R7: readback access ignores input
    xfer(12'b00_01_10101_011, 12);
    for (int i = 0; i < 6; i++) put_bit(1'b1);
    check("R7", "rb_req", int'(rbq), 1);
    check("R7", "rb_word", int'(rbw), 'h0AA8);
    for (int i = 0; i < 6; i++) put_bit(1'b1);
    frm = 1'b0; @(posedge clk); #1;
    check("R7", "chan after", int'(chan), 0);
    check("R7", "pair after", int'(pair), 1);
    check("R7", "dac after", int'(dac), 'h2AA);
    check("R7", "rb_req off", int'(rbq), 0);

    // R9: aborted access, arm preserved
    xfer(12'b11_11_00000_000, 7);
    check("R9", "chan unchanged", int'(chan), 0);
    xfer(12'b00_01_10101_001, 12);
    xfer(12'h0F0, 5);
    check("R9", "dac unchanged", int'(dac), 'h2AA);
    xfer(12'h0F0, 12);
    check("R9", "arm kept", int'(dac), 'h0F0);

    // R8: reset command and guard interval
    xfer(12'b10_01_11111_101, 12);
    check("R8", "pulse", int'(rst_p), 1);
    check("R8", "dac default", int'(dac), 'h3FF);
    check("R8", "chan default", int'(chan), 0);
    xfer(12'b11_11_00000_000, 12);
    check("R8", "word in gap lost", int'(chan), 0);
    check("R8", "pulse ended", int'(rst_p), 0);
    xfer(12'b11_00_00000_000, 12);
    check("R8", "after gap", int'(chan), 3);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule